// File: doc/BRIEF.md
# Snooping Four-State Cache Line Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache and decides, for each processor request and each transaction snooped from other caches, whether the line can be used at once, must be fetched, must be written back, or must change state. Each line stores a tag and a two-bit state: Invalid (00), Shared (01), Exclusive (10) or Modified (11). The data array, main memory and arbitration between caches live outside it.

On the processor side a request is held on `cpu_req` with an operation code and a line address until `cpu_done` pulses. `cpu_hit` marks requests finished without any bus traffic. On the bus side the controller raises `bus_req` with a command and line address, waits for `bus_gnt`, then waits for `bus_done`. Snooped transactions from other caches arrive on the `snp_*` pins. The controller answers a snoop with `snp_retry` when the other cache must back off and try again later.

Processor operation codes: 00 read, 01 write, 10 evict (drop the line), 11 clean (write back and keep the line). The same two-bit code is used for bus and snoop commands: 00 none, 01 read, 10 read-with-intent-to-own (which also invalidates other copies), 11 write-back. Snoops use only 01 and 10. The low `IDX_W` bits of a line address pick the line. The remaining upper bits form the tag.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (code 00), so `cpu_state` reads 00 for any address, and `bus_req` is low.
- R2: A read that hits a line in Modified, Exclusive or Shared completes in the cycle it is presented, with `cpu_done`=1 and `cpu_hit`=1. It causes no bus request.
- R3: A read to an Invalid or absent line issues a bus read (01) at that address. `cpu_done` pulses with `cpu_hit`=0 in the cycle `bus_done` is high. The line becomes Exclusive if `bus_shared` was low in that cycle, and Shared if it was high.
- R4: A write to an Exclusive line completes at once with `cpu_hit`=1 and leaves it Modified. A write to a Modified line completes at once and the line stays Modified.
- R5: A write to a Shared, Invalid or absent line issues a read-to-own (10) at that address. It completes with `cpu_hit`=0 when `bus_done` is seen, and the line ends Modified.
- R6: When a miss maps onto an index that holds a Modified line with another tag, that line is written back first (11, old tag with the same index). It becomes Invalid, and only then is the fetch issued.
- R7: Evicting a Shared or Exclusive line makes it Invalid at once with `cpu_hit`=1. Evicting a Modified line first writes it back, then makes it Invalid.
- R8: Cleaning a Modified line writes it back and leaves it Exclusive. Cleaning any other line completes at once with `cpu_hit`=1 and no state change.
- R9: A snooped read that matches a Modified line raises `snp_retry` in the same cycle, writes the line back, and leaves it Shared. A snooped read-to-own that matches a Modified line does the same but leaves it Invalid.
- R10: A snooped read on an Exclusive line makes it Shared. A snooped read-to-own on an Exclusive or Shared line makes it Invalid. A snooped read on a Shared line changes nothing. None of these raises `snp_retry`.
- R11: A Shared line is never promoted to Exclusive. A read hit on it leaves it Shared.
- R12: A matching snoop takes precedence over a processor request: the request stalls for the snoop cycle and through any write-back the snoop causes. Any snoop that arrives while the controller is busy with a bus sequence is answered with `snp_retry`.
- R13: While `bus_req` is high and `bus_gnt` low, `bus_req`, `bus_cmd` and `bus_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request held until done |
| cpu_op | input | 2 | Operation: 00 read, 01 write, 10 evict, 11 clean |
| cpu_addr | input | LADDR_W | Line address of the request |
| cpu_done | output | 1 | Request finished this cycle |
| cpu_hit | output | 1 | Finished without bus traffic |
| cpu_stall | output | 1 | Request pending, not finished |
| cpu_state | output | 2 | Current state of the line at cpu_addr (00 if tag differs) |
| bus_req | output | 1 | Bus request, held until grant |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Bus command: 01 read, 10 read-to-own, 11 write-back |
| bus_addr | output | LADDR_W | Line address of the bus command |
| bus_done | input | 1 | Bus transaction finished |
| bus_shared | input | 1 | Another cache holds the line, sampled with bus_done |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command: 01 read, 10 read-to-own |
| snp_addr | input | LADDR_W | Snooped line address |
| snp_retry | output | 1 | Snooping cache must back off and retry |

## Verification
The assertions check the per-cycle rules on every cycle: a snoop hitting a Modified line always raises retry, a write-hit only ever completes from Modified or Exclusive, and a finished write leaves the line Modified. They also check that a finished eviction leaves it Invalid, that a Shared line never turns Exclusive, and that bus requests stay stable until granted. Only the directed scenarios can show the multi-step orderings: a dirty victim written back before the fill, the fill state chosen from the shared-sense input, and a snoop write-back ending in Shared versus Invalid. The scenarios also cover a processor request stalled behind a snoop and then hitting, and retry for snoops during a busy sequence.

// File: rtl/cohctl_pkg.sv
package cohctl_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2,
        OP_CLEAN = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_READ  = 2'd1,
        BC_OWN   = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CS_IDLE = 3'd0,
        CS_VICT = 3'd1,
        CS_FILL = 3'd2,
        CS_LWB  = 3'd3,
        CS_SWB  = 3'd4
    } ctl_st_e;

    typedef struct packed {
        logic     upd;
        line_st_e nxt;
        logic     wb;
    } snp_act_t;

    function automatic logic st_valid(line_st_e s);
        return s != LS_INV;
    endfunction

    function automatic line_st_e fill_state(logic for_write, logic shared_seen);
        if (for_write)
            return LS_MOD;
        return shared_seen ? LS_SHR : LS_EXC;
    endfunction

endpackage

// File: rtl/cohctl_tag_array.sv
module cohctl_tag_array
    import cohctl_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [TAG_W-1:0] ra_tag,
    output line_st_e         ra_st,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [TAG_W-1:0] rb_tag,
    output line_st_e         rb_st,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  line_st_e         w_st
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_v [LINES];
    line_st_e         st_v  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_r;
        line_st_e         st_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_r <= '0;
                st_r  <= LS_INV;
            end else if (we && (w_idx == IDX_W'(g))) begin
                tag_r <= w_tag;
                st_r  <= w_st;
            end
        end

        assign tag_v[g] = tag_r;
        assign st_v[g]  = st_r;
    end

    assign ra_tag = tag_v[ra_idx];
    assign ra_st  = st_v[ra_idx];
    assign rb_tag = tag_v[rb_idx];
    assign rb_st  = st_v[rb_idx];

endmodule

// File: rtl/cohctl_snoop_eval.sv
module cohctl_snoop_eval
    import cohctl_pkg::*;
(
    input  logic     hit,
    input  line_st_e st,
    input  bus_cmd_e cmd,
    output snp_act_t act
);
    logic is_rd;
    logic is_own;

    assign is_rd  = (cmd == BC_READ);
    assign is_own = (cmd == BC_OWN);

    always_comb begin
        act.upd = 1'b0;
        act.nxt = st;
        act.wb  = 1'b0;
        if (hit) begin
            case (st)
                LS_MOD: begin
                    if (is_rd || is_own) begin
                        act.wb  = 1'b1;
                        act.upd = 1'b1;
                        act.nxt = is_rd ? LS_SHR : LS_INV;
                    end
                end
                LS_EXC: begin
                    if (is_rd) begin
                        act.upd = 1'b1;
                        act.nxt = LS_SHR;
                    end else if (is_own) begin
                        act.upd = 1'b1;
                        act.nxt = LS_INV;
                    end
                end
                LS_SHR: begin
                    if (is_own) begin
                        act.upd = 1'b1;
                        act.nxt = LS_INV;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cohctl_bus_port.sv
module cohctl_bus_port
    import cohctl_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  bus_cmd_e      cmd,
    input  logic [AW-1:0] addr,
    input  logic          bus_gnt,
    input  logic          bus_done,
    input  logic          bus_shared,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic          fin,
    output logic          fin_shared
);
    typedef enum logic [1:0] {BP_IDLE, BP_ASK, BP_OWN} bp_e;

    bp_e           phase;
    bus_cmd_e      cmd_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= BP_IDLE;
            cmd_q  <= BC_NONE;
            addr_q <= '0;
        end else if (start) begin
            phase  <= BP_ASK;
            cmd_q  <= cmd;
            addr_q <= addr;
        end else begin
            case (phase)
                BP_ASK:  if (bus_gnt)  phase <= BP_OWN;
                BP_OWN:  if (bus_done) phase <= BP_IDLE;
                default: ;
            endcase
        end
    end

    assign bus_req    = (phase == BP_ASK);
    assign bus_cmd    = (phase == BP_IDLE) ? BC_NONE : cmd_q;
    assign bus_addr   = addr_q;
    assign fin        = (phase == BP_OWN) && bus_done;
    assign fin_shared = fin && bus_shared;

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import cohctl_pkg::*;
#(
    parameter int LADDR_W = 10,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic [1:0]         cpu_op,
    input  logic [LADDR_W-1:0] cpu_addr,
    output logic               cpu_done,
    output logic               cpu_hit,
    output logic               cpu_stall,
    output logic [1:0]         cpu_state,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd,
    output logic [LADDR_W-1:0] bus_addr,
    input  logic               bus_done,
    input  logic               bus_shared,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [LADDR_W-1:0] snp_addr,
    output logic               snp_retry
);
    localparam int TAG_W = LADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx;
    logic [TAG_W-1:0] cpu_tag;
    logic [IDX_W-1:0] snp_idx;
    logic [TAG_W-1:0] snp_tag;
    logic [TAG_W-1:0] ra_tag, rb_tag;
    line_st_e         ra_st, rb_st;
    logic             we;
    logic [IDX_W-1:0] w_idx;
    logic [TAG_W-1:0] w_tag;
    line_st_e         w_st;

    logic             c_hit;
    logic             victim_dirty;
    line_st_e         cpu_line_st;
    logic             snp_on;
    logic             snp_match;
    line_st_e         snp_line_st;
    snp_act_t         s_act;

    logic               bp_start;
    bus_cmd_e           bp_cmd;
    logic [LADDR_W-1:0] bp_addr;
    logic               bp_fin;
    logic               bp_fin_shared;

    ctl_st_e            ctl_q, ctl_d;
    cpu_op_e            op_q;
    logic [LADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]   sidx_q;
    logic [TAG_W-1:0]   stag_q;
    line_st_e           star_q;

    logic done_c, hit_c;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[LADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[LADDR_W-1:IDX_W];

    cohctl_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .ra_idx (cpu_idx),
        .ra_tag (ra_tag),
        .ra_st  (ra_st),
        .rb_idx (snp_idx),
        .rb_tag (rb_tag),
        .rb_st  (rb_st),
        .we     (we),
        .w_idx  (w_idx),
        .w_tag  (w_tag),
        .w_st   (w_st)
    );

    assign c_hit        = (ra_tag == cpu_tag) && st_valid(ra_st);
    assign victim_dirty = !c_hit && (ra_st == LS_MOD);
    assign cpu_line_st  = c_hit ? ra_st : LS_INV;
    assign cpu_state    = cpu_line_st;

    assign snp_on      = snp_valid && ((snp_cmd == BC_READ) || (snp_cmd == BC_OWN));
    assign snp_match   = snp_on && (rb_tag == snp_tag) && st_valid(rb_st);
    assign snp_line_st = snp_match ? rb_st : LS_INV;

    cohctl_snoop_eval u_snp (
        .hit (snp_match),
        .st  (rb_st),
        .cmd (bus_cmd_e'(snp_cmd)),
        .act (s_act)
    );

    cohctl_bus_port #(.AW(LADDR_W)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .start      (bp_start),
        .cmd        (bp_cmd),
        .addr       (bp_addr),
        .bus_gnt    (bus_gnt),
        .bus_done   (bus_done),
        .bus_shared (bus_shared),
        .bus_req    (bus_req),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .fin        (bp_fin),
        .fin_shared (bp_fin_shared)
    );

    always_comb begin
        ctl_d    = ctl_q;
        we       = 1'b0;
        w_idx    = cpu_idx;
        w_tag    = cpu_tag;
        w_st     = LS_INV;
        bp_start = 1'b0;
        bp_cmd   = BC_NONE;
        bp_addr  = cpu_addr;
        done_c   = 1'b0;
        hit_c    = 1'b0;
        case (ctl_q)
            CS_IDLE: begin
                if (snp_match) begin
                    if (s_act.wb) begin
                        bp_start = 1'b1;
                        bp_cmd   = BC_WBACK;
                        bp_addr  = snp_addr;
                        ctl_d    = CS_SWB;
                    end else if (s_act.upd) begin
                        we    = 1'b1;
                        w_idx = snp_idx;
                        w_tag = rb_tag;
                        w_st  = s_act.nxt;
                    end
                end else if (cpu_req) begin
                    case (cpu_op_e'(cpu_op))
                        OP_RD, OP_WR: begin
                            if (c_hit && (ra_st == LS_MOD || ra_st == LS_EXC ||
                                          cpu_op_e'(cpu_op) == OP_RD)) begin
                                done_c = 1'b1;
                                hit_c  = 1'b1;
                                if (cpu_op_e'(cpu_op) == OP_WR && ra_st == LS_EXC) begin
                                    we   = 1'b1;
                                    w_st = LS_MOD;
                                end
                            end else if (victim_dirty) begin
                                bp_start = 1'b1;
                                bp_cmd   = BC_WBACK;
                                bp_addr  = {ra_tag, cpu_idx};
                                ctl_d    = CS_VICT;
                            end else begin
                                bp_start = 1'b1;
                                bp_cmd   = (cpu_op_e'(cpu_op) == OP_WR) ? BC_OWN : BC_READ;
                                ctl_d    = CS_FILL;
                            end
                        end
                        OP_EVICT, OP_CLEAN: begin
                            if (c_hit && ra_st == LS_MOD) begin
                                bp_start = 1'b1;
                                bp_cmd   = BC_WBACK;
                                ctl_d    = CS_LWB;
                            end else begin
                                done_c = 1'b1;
                                hit_c  = 1'b1;
                                if (c_hit && cpu_op_e'(cpu_op) == OP_EVICT) begin
                                    we   = 1'b1;
                                    w_st = LS_INV;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            CS_VICT: begin
                if (bp_fin) begin
                    we       = 1'b1;
                    w_idx    = addr_q[IDX_W-1:0];
                    w_tag    = addr_q[LADDR_W-1:IDX_W];
                    w_st     = LS_INV;
                    bp_start = 1'b1;
                    bp_cmd   = (op_q == OP_WR) ? BC_OWN : BC_READ;
                    bp_addr  = addr_q;
                    ctl_d    = CS_FILL;
                end
            end
            CS_FILL: begin
                if (bp_fin) begin
                    we     = 1'b1;
                    w_idx  = addr_q[IDX_W-1:0];
                    w_tag  = addr_q[LADDR_W-1:IDX_W];
                    w_st   = fill_state(op_q == OP_WR, bp_fin_shared);
                    done_c = 1'b1;
                    ctl_d  = CS_IDLE;
                end
            end
            CS_LWB: begin
                if (bp_fin) begin
                    we     = 1'b1;
                    w_idx  = addr_q[IDX_W-1:0];
                    w_tag  = addr_q[LADDR_W-1:IDX_W];
                    w_st   = (op_q == OP_EVICT) ? LS_INV : LS_EXC;
                    done_c = 1'b1;
                    ctl_d  = CS_IDLE;
                end
            end
            CS_SWB: begin
                if (bp_fin) begin
                    we    = 1'b1;
                    w_idx = sidx_q;
                    w_tag = stag_q;
                    w_st  = star_q;
                    ctl_d = CS_IDLE;
                end
            end
            default: ctl_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CS_IDLE;
            op_q   <= OP_RD;
            addr_q <= '0;
            sidx_q <= '0;
            stag_q <= '0;
            star_q <= LS_INV;
        end else begin
            ctl_q <= ctl_d;
            if (ctl_q == CS_IDLE) begin
                op_q   <= cpu_op_e'(cpu_op);
                addr_q <= cpu_addr;
                if (snp_match) begin
                    sidx_q <= snp_idx;
                    stag_q <= snp_tag;
                    star_q <= s_act.nxt;
                end
            end
        end
    end

    assign cpu_done  = done_c;
    assign cpu_hit   = hit_c;
    assign cpu_stall = cpu_req && !done_c;
    assign snp_retry = snp_on && ((ctl_q != CS_IDLE) || (snp_match && s_act.wb));

endmodule

// File: rtl/cohctl_chk.sv
module cohctl_chk
    import cohctl_pkg::*;
#(
    parameter int LADDR_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         cpu_op,
    input logic [LADDR_W-1:0] cpu_addr,
    input logic               cpu_done,
    input logic               cpu_hit,
    input logic [1:0]         cpu_state,
    input logic               bus_req,
    input logic               bus_gnt,
    input logic [1:0]         bus_cmd,
    input logic [LADDR_W-1:0] bus_addr,
    input logic               snp_valid,
    input logic               snp_match,
    input line_st_e           snp_line_st,
    input logic               snp_retry
);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (!bus_req && cpu_state == LS_INV));

    // R2
    rd_hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_hit && cpu_op == OP_RD) |-> (cpu_state != LS_INV));

    // R4
    wr_hit_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_hit && cpu_op == OP_WR) |->
        (cpu_state == LS_MOD || cpu_state == LS_EXC));

    // R5
    wr_ends_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_op == OP_WR) |=> (!$stable(cpu_addr) || cpu_state == LS_MOD));

    // R7
    evict_ends_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_op == OP_EVICT) |=> (!$stable(cpu_addr) || cpu_state == LS_INV));

    // R9
    mod_snoop_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_match && snp_line_st == LS_MOD) |-> snp_retry);

    // R11
    shr_no_promote_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_state == LS_SHR) |=> (!$stable(cpu_addr) || cpu_state != LS_EXC));

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

endmodule

bind coh_line_ctrl cohctl_chk #(.LADDR_W(LADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_op      (cpu_op),
    .cpu_addr    (cpu_addr),
    .cpu_done    (cpu_done),
    .cpu_hit     (cpu_hit),
    .cpu_state   (cpu_state),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .snp_valid   (snp_valid),
    .snp_match   (snp_match),
    .snp_line_st (snp_line_st),
    .snp_retry   (snp_retry)
);

// File: tb/sim_coh_line_ctrl.sv
`timescale 1ns/1ps
module sim_coh_line_ctrl;
    localparam int AW = 10;
    localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
    localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_EV = 2'd2, O_CL = 2'd3;
    localparam logic [1:0] B_RD = 2'd1, B_OWN = 2'd2, B_WB = 2'd3;
    localparam logic [AW-1:0] A_ADR = 10'h005, B_ADR = 10'h00D, C_ADR = 10'h013, D_ADR = 10'h002;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_done, cpu_hit, cpu_stall;
    logic [1:0]    cpu_state;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_done = 1'b0;
    logic          bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_retry;

    int  errs = 0;
    int  checks = 0;
    bit  ended = 1'b0;

    always #4 clk = ~clk;

    coh_line_ctrl #(.LADDR_W(AW), .IDX_W(3)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .cpu_state(cpu_state),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_done(bus_done), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_retry(snp_retry)
    );

    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic state_is(logic [AW-1:0] a, logic [1:0] exp, string req);
        cpu_addr = a;
        #1;
        chk_eq(req, "line state", cpu_state, exp);
    endtask

    task automatic cpu_now(logic [1:0] op, logic [AW-1:0] a, bit exp_hit, string req);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = op; cpu_addr = a;
        #1;
        chk_eq(req, "immediate done", cpu_done, 1);
        chk_eq(req, "hit flag", cpu_hit, exp_hit);
        chk_eq(req, "no bus request", bus_req, 0);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_issue(logic [1:0] op, logic [AW-1:0] a, string req);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = op; cpu_addr = a;
        #1;
        chk_eq(req, "not done at issue", cpu_done, 0);
        chk_eq(req, "stall at issue", cpu_stall, 1);
    endtask

    task automatic bus_txn(logic [1:0] ecmd, logic [AW-1:0] ea, bit shr,
                           bit chk_done, bit exp_done, string req);
        int w = 0;
        while (!bus_req && w < 40) begin
            @(negedge clk);
            w++;
        end
        chk_eq(req, "bus command", bus_cmd, ecmd);
        chk_eq(req, "bus address", bus_addr, ea);
        @(negedge clk);
        chk_eq("R13", "request held without grant", bus_req, 1);
        chk_eq("R13", "command held without grant", bus_cmd, ecmd);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        bus_done = 1'b1;
        bus_shared = shr;
        #1;
        if (chk_done) begin
            chk_eq(req, "done at bus end", cpu_done, exp_done);
            if (exp_done) chk_eq(req, "miss flag", cpu_hit, 0);
        end
        @(negedge clk);
        bus_done = 1'b0;
        bus_shared = 1'b0;
    endtask

    task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a, bit exp_retry, string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        #1;
        chk_eq(req, "snoop retry", snp_retry, exp_retry);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
    endtask

    task automatic t_reset;
        state_is(A_ADR, ST_I, "R1");
        state_is(C_ADR, ST_I, "R1");
        chk_eq("R1", "bus idle", bus_req, 0);
    endtask

    task automatic t_read_fill;
        cpu_issue(O_RD, A_ADR, "R3");
        bus_txn(B_RD, A_ADR, 1'b0, 1'b1, 1'b1, "R3");
        cpu_req = 1'b0;
        state_is(A_ADR, ST_E, "R3");
        state_is(B_ADR, ST_I, "R3");
        cpu_now(O_RD, A_ADR, 1'b1, "R2");
        state_is(A_ADR, ST_E, "R2");
    endtask

    task automatic t_write_hits;
        cpu_now(O_WR, A_ADR, 1'b1, "R4");
        state_is(A_ADR, ST_M, "R4");
        cpu_now(O_WR, A_ADR, 1'b1, "R4");
        state_is(A_ADR, ST_M, "R4");
        cpu_now(O_RD, A_ADR, 1'b1, "R2");
    endtask

    task automatic t_snoop_mod_read;
        snoop(B_RD, A_ADR, 1'b1, "R9");
        bus_txn(B_WB, A_ADR, 1'b0, 1'b0, 1'b0, "R9");
        state_is(A_ADR, ST_S, "R9");
    endtask

    task automatic t_shared_rules;
        cpu_now(O_RD, A_ADR, 1'b1, "R11");
        state_is(A_ADR, ST_S, "R11");
        snoop(B_RD, A_ADR, 1'b0, "R10");
        state_is(A_ADR, ST_S, "R10");
        snoop(B_OWN, A_ADR, 1'b0, "R10");
        state_is(A_ADR, ST_I, "R10");
    endtask

    task automatic t_own_and_victim;
        cpu_issue(O_WR, A_ADR, "R5");
        bus_txn(B_OWN, A_ADR, 1'b0, 1'b1, 1'b1, "R5");
        cpu_req = 1'b0;
        state_is(A_ADR, ST_M, "R5");
        cpu_issue(O_RD, B_ADR, "R6");
        bus_txn(B_WB, A_ADR, 1'b0, 1'b1, 1'b0, "R6");
        bus_txn(B_RD, B_ADR, 1'b1, 1'b1, 1'b1, "R6");
        cpu_req = 1'b0;
        state_is(B_ADR, ST_S, "R3");
        state_is(A_ADR, ST_I, "R6");
        cpu_issue(O_WR, B_ADR, "R5");
        bus_txn(B_OWN, B_ADR, 1'b0, 1'b1, 1'b1, "R5");
        cpu_req = 1'b0;
        state_is(B_ADR, ST_M, "R5");
    endtask

    task automatic t_clean;
        cpu_issue(O_CL, B_ADR, "R8");
        bus_txn(B_WB, B_ADR, 1'b0, 1'b1, 1'b1, "R8");
        cpu_req = 1'b0;
        state_is(B_ADR, ST_E, "R8");
        cpu_now(O_CL, B_ADR, 1'b1, "R8");
        state_is(B_ADR, ST_E, "R8");
    endtask

    task automatic t_evict;
        snoop(B_RD, B_ADR, 1'b0, "R10");
        state_is(B_ADR, ST_S, "R10");
        cpu_now(O_EV, B_ADR, 1'b1, "R7");
        state_is(B_ADR, ST_I, "R7");
        cpu_issue(O_WR, A_ADR, "R5");
        bus_txn(B_OWN, A_ADR, 1'b0, 1'b1, 1'b1, "R5");
        cpu_req = 1'b0;
        cpu_issue(O_EV, A_ADR, "R7");
        bus_txn(B_WB, A_ADR, 1'b0, 1'b1, 1'b1, "R7");
        cpu_req = 1'b0;
        state_is(A_ADR, ST_I, "R7");
    endtask

    task automatic t_snoop_mod_own;
        cpu_issue(O_WR, C_ADR, "R5");
        bus_txn(B_OWN, C_ADR, 1'b0, 1'b1, 1'b1, "R5");
        cpu_req = 1'b0;
        snoop(B_OWN, C_ADR, 1'b1, "R9");
        bus_txn(B_WB, C_ADR, 1'b0, 1'b0, 1'b0, "R9");
        state_is(C_ADR, ST_I, "R9");
        cpu_issue(O_RD, C_ADR, "R3");
        bus_txn(B_RD, C_ADR, 1'b0, 1'b1, 1'b1, "R3");
        cpu_req = 1'b0;
        snoop(B_OWN, C_ADR, 1'b0, "R10");
        state_is(C_ADR, ST_I, "R10");
    endtask

    task automatic t_priority;
        cpu_issue(O_WR, C_ADR, "R5");
        bus_txn(B_OWN, C_ADR, 1'b0, 1'b1, 1'b1, "R5");
        cpu_req = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = O_RD; cpu_addr = C_ADR;
        snp_valid = 1'b1; snp_cmd = B_RD; snp_addr = C_ADR;
        #1;
        chk_eq("R12", "retry on conflicting snoop", snp_retry, 1);
        chk_eq("R12", "cpu stalled by snoop", cpu_done, 0);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
        #1;
        chk_eq("R12", "stall during snoop write-back", cpu_stall, 1);
        bus_txn(B_WB, C_ADR, 1'b0, 1'b1, 1'b0, "R12");
        #1;
        chk_eq("R12", "done after snoop write-back", cpu_done, 1);
        chk_eq("R12", "hit after snoop write-back", cpu_hit, 1);
        chk_eq("R12", "line shared after snoop", cpu_state, ST_S);
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_issue(O_RD, D_ADR, "R3");
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = B_RD; snp_addr = A_ADR;
        #1;
        chk_eq("R12", "retry while busy", snp_retry, 1);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
        bus_txn(B_RD, D_ADR, 1'b0, 1'b1, 1'b1, "R3");
        cpu_req = 1'b0;
        state_is(D_ADR, ST_E, "R3");
    endtask

    initial begin
        #(200000 * 8);
        if (!ended) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_fill();
        t_write_hits();
        t_snoop_mod_read();
        t_shared_rules();
        t_own_and_victim();
        t_clean();
        t_evict();
        t_snoop_mod_own();
        t_priority();
        repeat (2) @(negedge clk);
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule